// File: doc/BRIEF.md
# IRQ Exception Entry Unit with Secure Routing

This block computes, in one clock, the register updates a processor core makes when it accepts an interrupt request. It reads the current status word, two secure-configuration controls, the endianness bits of the secure and non-secure system control registers, the vectoring controls, the vector base addresses, an externally supplied handler address and the address of the next instruction. From these it produces the new status word, the saved status word, the link value, a bank select and the new program counter.

An interrupt is accepted only when it is requested and the status word's IRQ mask bit is clear. An accepted interrupt goes one of two ways. It is trapped to the secure monitor when the trap control is set. Otherwise it enters IRQ mode. On the IRQ-mode path the handler address comes from one of three places: the externally supplied handler address, the fixed high vector, or the non-secure base address plus the IRQ vector offset. The outputs are registered. They change only in the cycle after an accepted request, and a one-cycle strobe marks each update so the register file can write the banked link and saved-status registers.

Top module: `irq_entry_unit`

## Requirements
- R1: When `irq_req` is 0, or `cpsr_in[7]` is 1, `update_stb` is 0 in the next cycle and every other output keeps its value.
- R2: An accepted interrupt with `trap_to_monitor`=1 sets `bank_monitor`=1, sets `cpsr_out[4:0]`=5'b10110 and sets `pc_out`=`monitor_base`+0x18. The vectoring controls have no effect on this path.
- R3: On the monitor path, `cpsr_out` bits 6, 7 and 8 are 1, and bit 9 equals `ee_secure`.
- R4: An accepted interrupt with `trap_to_monitor`=0 sets `bank_monitor`=0, `cpsr_out[4:0]`=5'b10010 and `cpsr_out[7]`=1. Bit 6 keeps its value from `cpsr_in`.
- R5: On the IRQ-mode path, `cpsr_out[8]` is 1 when `abort_mask_on_irq`=1 and otherwise equals `cpsr_in[8]`. Bit 9 equals `ee_nonsecure`.
- R6: On both paths, `cpsr_out` bit 5 and bit 24 are 0.
- R7: After every accepted interrupt, `update_stb` is 1 for exactly that cycle, `link_out` = `next_instr_addr`+4 and `spsr_out` = the whole `cpsr_in`.
- R8: On the IRQ-mode path with `vectored_en`=1, `pc_out` = `handler_addr`, whatever the value of `high_vectors`.
- R9: On the IRQ-mode path with `vectored_en`=0, `pc_out` = 0xFFFF0018 when `high_vectors`=1. Otherwise `pc_out` = `nonsecure_base`+0x18.
- R10: Every `cpsr_out` bit not named in R2 to R6, including the flags [31:28], equals the same bit of `cpsr_in`.
- R11: While `rst_n` is 0 at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request |
| cpsr_in | input | 32 | Current program status word |
| trap_to_monitor | input | 1 | Secure configuration: route IRQ to monitor |
| abort_mask_on_irq | input | 1 | Secure configuration: mask imprecise aborts on IRQ entry |
| ee_secure | input | 1 | Endianness bit of the secure control register |
| ee_nonsecure | input | 1 | Endianness bit of the non-secure control register |
| vectored_en | input | 1 | Use the external handler address |
| high_vectors | input | 1 | Select the high vector table |
| monitor_base | input | 32 | Monitor vector base address |
| nonsecure_base | input | 32 | Non-secure vector base address |
| handler_addr | input | 32 | Externally supplied handler address |
| next_instr_addr | input | 32 | Address of the next instruction |
| cpsr_out | output | 32 | New status word |
| spsr_out | output | 32 | Saved status word for the target bank |
| link_out | output | 32 | Link value for the target bank |
| bank_monitor | output | 1 | 1: monitor bank, 0: IRQ bank |
| pc_out | output | 32 | New program counter |
| update_stb | output | 1 | One-cycle strobe marking an update |

## Verification
The hardest case to reach is a request that arrives while the mask bit is set, just after an accepted entry whose outputs differ from the reset values. Only in that case can a faulty design that rewrites its outputs on a masked request be told apart from one that holds them. To reach it, the stimulus first takes an interrupt so that every output holds a distinctive value. It then applies requests with bit 7 set, and cycles with no request, whose other inputs are all different. Separate sweeps cover all sixteen combinations of the trap, abort-mask, vectoring and high-vector controls, each with varied flag and mask bits in the incoming status word.

// File: rtl/irq_entry_pkg.sv
// Shared definitions for the IRQ exception entry unit.
// Assumes a 32-bit status word with the mode field in [4:0].
package irq_entry_pkg;

    // Outcome of the acceptance and routing decision
    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_IRQ  = 2'd1,
        ROUTE_MON  = 2'd2
    } route_e;

    localparam logic [4:0] MODE_MONITOR = 5'b10110;
    localparam logic [4:0] MODE_IRQ     = 5'b10010;

    // Status word bit positions that entry modifies
    localparam int PSR_BIT_T = 5;
    localparam int PSR_BIT_F = 6;
    localparam int PSR_BIT_I = 7;
    localparam int PSR_BIT_A = 8;
    localparam int PSR_BIT_E = 9;
    localparam int PSR_BIT_J = 24;

    localparam int VEC_IRQ_OFFSET = 'h18;
    localparam int LINK_ADJUST    = 4;

endpackage

// File: rtl/irq_route_dec.sv
// Decides whether an interrupt request is accepted and where it goes.
// Assumes all inputs are stable for the cycle. Purely combinational.
module irq_route_dec
    import irq_entry_pkg::*;
(
    input  logic   req,
    input  logic   irq_masked,
    input  logic   trap_mon,
    output route_e route
);

    // Masked or absent requests produce no route; otherwise the trap picks the path
    always_comb begin
        if (!req || irq_masked)
            route = ROUTE_NONE;
        else if (trap_mon)
            route = ROUTE_MON;
        else
            route = ROUTE_IRQ;
    end

endmodule

// File: rtl/irq_psr_build.sv
// Builds the post-entry status word from the pre-entry one.
// Assumes PSR_W is wide enough to hold bit 24. Bits that entry does
// not name pass through unchanged. Purely combinational.
module irq_psr_build
    import irq_entry_pkg::*;
#(
    parameter int PSR_W = 32
) (
    input  route_e             route,
    input  logic [PSR_W-1:0]   psr_in,
    input  logic               abort_mask_irq,
    input  logic               ee_s,
    input  logic               ee_ns,
    output logic [PSR_W-1:0]   psr_new
);

    // Apply the mode-specific masking, endianness and state-clear rules
    always_comb begin
        psr_new = psr_in;
        case (route)
            ROUTE_MON: begin
                psr_new[4:0]      = MODE_MONITOR;
                psr_new[PSR_BIT_F] = 1'b1;
                psr_new[PSR_BIT_I] = 1'b1;
                psr_new[PSR_BIT_A] = 1'b1;
                psr_new[PSR_BIT_E] = ee_s;
            end
            ROUTE_IRQ: begin
                psr_new[4:0]      = MODE_IRQ;
                psr_new[PSR_BIT_I] = 1'b1;
                if (abort_mask_irq)
                    psr_new[PSR_BIT_A] = 1'b1;
                psr_new[PSR_BIT_E] = ee_ns;
            end
            default: ;
        endcase
        if (route != ROUTE_NONE) begin
            psr_new[PSR_BIT_T] = 1'b0;
            psr_new[PSR_BIT_J] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_vector_sel.sv
// Selects the handler address for an accepted interrupt.
// Assumes ADDR_W >= 16. The monitor path always uses its own base.
// Purely combinational.
module irq_vector_sel
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  route_e             route,
    input  logic               vic_en,
    input  logic               hivec,
    input  logic [ADDR_W-1:0]  mon_base,
    input  logic [ADDR_W-1:0]  ns_base,
    input  logic [ADDR_W-1:0]  ext_addr,
    output logic [ADDR_W-1:0]  target
);

    localparam logic [ADDR_W-1:0] OFS_IRQ   = ADDR_W'(VEC_IRQ_OFFSET);
    localparam logic [ADDR_W-1:0] HIGH_ADDR = {{(ADDR_W-16){1'b1}}, 16'h0000} | OFS_IRQ;

    // Priority: monitor base, then vectored address, then high or banked table
    always_comb begin
        case (route)
            ROUTE_MON: target = mon_base + OFS_IRQ;
            ROUTE_IRQ: begin
                if (vic_en)
                    target = ext_addr;
                else if (hivec)
                    target = HIGH_ADDR;
                else
                    target = ns_base + OFS_IRQ;
            end
            default:   target = '0;
        endcase
    end

endmodule

// File: rtl/irq_entry_unit.sv
// IRQ exception entry unit: registers the status, saved status, link,
// bank select and program counter updates for an accepted interrupt.
// Assumes a synchronous active-low reset and that the consumer writes
// its banked registers when update_stb is high.
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int PSR_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [PSR_W-1:0]  cpsr_in,
    input  logic              trap_to_monitor,
    input  logic              abort_mask_on_irq,
    input  logic              ee_secure,
    input  logic              ee_nonsecure,
    input  logic              vectored_en,
    input  logic              high_vectors,
    input  logic [ADDR_W-1:0] monitor_base,
    input  logic [ADDR_W-1:0] nonsecure_base,
    input  logic [ADDR_W-1:0] handler_addr,
    input  logic [ADDR_W-1:0] next_instr_addr,
    output logic [PSR_W-1:0]  cpsr_out,
    output logic [PSR_W-1:0]  spsr_out,
    output logic [ADDR_W-1:0] link_out,
    output logic              bank_monitor,
    output logic [ADDR_W-1:0] pc_out,
    output logic              update_stb
);

    localparam logic [ADDR_W-1:0] LINK_OFS = ADDR_W'(LINK_ADJUST);

    route_e             route;
    logic [PSR_W-1:0]   psr_next;
    logic [ADDR_W-1:0]  pc_next;
    logic               take;

    irq_route_dec u_route (
        .req        (irq_req),
        .irq_masked (cpsr_in[PSR_BIT_I]),
        .trap_mon   (trap_to_monitor),
        .route      (route)
    );

    irq_psr_build #(.PSR_W(PSR_W)) u_psr (
        .route          (route),
        .psr_in         (cpsr_in),
        .abort_mask_irq (abort_mask_on_irq),
        .ee_s           (ee_secure),
        .ee_ns          (ee_nonsecure),
        .psr_new        (psr_next)
    );

    irq_vector_sel #(.ADDR_W(ADDR_W)) u_vec (
        .route    (route),
        .vic_en   (vectored_en),
        .hivec    (high_vectors),
        .mon_base (monitor_base),
        .ns_base  (nonsecure_base),
        .ext_addr (handler_addr),
        .target   (pc_next)
    );

    assign take = (route != ROUTE_NONE);

    // Capture the entry results on acceptance; hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_out     <= '0;
            spsr_out     <= '0;
            link_out     <= '0;
            bank_monitor <= 1'b0;
            pc_out       <= '0;
            update_stb   <= 1'b0;
        end else begin
            update_stb <= take;
            if (take) begin
                cpsr_out     <= psr_next;
                spsr_out     <= cpsr_in;
                link_out     <= next_instr_addr + LINK_OFS;
                bank_monitor <= (route == ROUTE_MON);
                pc_out       <= pc_next;
            end
        end
    end

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req || cpsr_in[PSR_BIT_I]) |=> (!update_stb && $stable(pc_out) && $stable(cpsr_out))); // R1
    AST_MON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpsr_in[PSR_BIT_I] && trap_to_monitor) |=>
        (bank_monitor && cpsr_out[4:0] == MODE_MONITOR && cpsr_out[8:6] == 3'b111)); // R3
    AST_IRQ_FIQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpsr_in[PSR_BIT_I] && !trap_to_monitor) |=>
        (!bank_monitor && cpsr_out[PSR_BIT_F] == $past(cpsr_in[PSR_BIT_F]))); // R4
    AST_STATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> (!cpsr_out[PSR_BIT_T] && !cpsr_out[PSR_BIT_J])); // R6
    AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpsr_in[PSR_BIT_I]) |=>
        (update_stb && link_out == $past(next_instr_addr) + LINK_OFS && spsr_out == $past(cpsr_in))); // R7
    AST_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> (cpsr_out[PSR_W-1:PSR_W-4] == spsr_out[PSR_W-1:PSR_W-4])); // R10

endmodule

// File: tb/irq_entry_unit_tb.sv
module irq_entry_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req;
    logic [31:0] cpsr_in;
    logic        trap_to_monitor, abort_mask_on_irq, ee_secure, ee_nonsecure;
    logic        vectored_en, high_vectors;
    logic [31:0] monitor_base, nonsecure_base, handler_addr, next_instr_addr;
    logic [31:0] cpsr_out, spsr_out, link_out, pc_out;
    logic        bank_monitor, update_stb;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [31:0] m_cpsr, m_spsr, m_link, m_pc;
    logic        m_bank, m_stb;

    always #2 clk = ~clk;

    irq_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cpsr_in(cpsr_in),
        .trap_to_monitor(trap_to_monitor), .abort_mask_on_irq(abort_mask_on_irq),
        .ee_secure(ee_secure), .ee_nonsecure(ee_nonsecure),
        .vectored_en(vectored_en), .high_vectors(high_vectors),
        .monitor_base(monitor_base), .nonsecure_base(nonsecure_base),
        .handler_addr(handler_addr), .next_instr_addr(next_instr_addr),
        .cpsr_out(cpsr_out), .spsr_out(spsr_out), .link_out(link_out),
        .bank_monitor(bank_monitor), .pc_out(pc_out), .update_stb(update_stb)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // behavioural reference: applied once per clock edge to the sampled inputs
    task automatic model_step();
        logic [31:0] nw;
        if (!rst_n) begin
            m_cpsr = 0; m_spsr = 0; m_link = 0; m_pc = 0; m_bank = 0; m_stb = 0;
        end else if (irq_req && (cpsr_in & 32'h80) == 0) begin
            m_stb  = 1;
            m_spsr = cpsr_in;
            m_link = next_instr_addr + 4;
            nw = cpsr_in & ~32'h0100_03FF;
            nw = nw | (cpsr_in & 32'h0000_0140);
            if (trap_to_monitor) begin
                nw = (nw & ~32'h1F0) | 32'h1C0 | 32'h16 | (ee_secure ? 32'h200 : 0);
                m_pc = monitor_base + 32'h18;
                m_bank = 1;
            end else begin
                nw = nw | 32'h80 | 32'h12 | (abort_mask_on_irq ? 32'h100 : 0) | (ee_nonsecure ? 32'h200 : 0);
                m_bank = 0;
                if (vectored_en)       m_pc = handler_addr;
                else if (high_vectors) m_pc = 32'hFFFF_0018;
                else                   m_pc = nonsecure_base + 32'h18;
            end
            m_cpsr = nw;
        end else begin
            m_stb = 0;
        end
    endtask

    task automatic compare(input bit took, input bit mon, input bit ve);
        string rp;
        if (!rst_n) begin
            chk(cpsr_out == 0 && spsr_out == 0 && link_out == 0 && pc_out == 0
                && !bank_monitor && !update_stb, "R11 reset", cpsr_out | pc_out, 0);
            return;
        end
        if (!took) begin
            chk(update_stb == 0, "R1 strobe", 32'(update_stb), 0);
            chk(cpsr_out == m_cpsr && pc_out == m_pc && link_out == m_link
                && spsr_out == m_spsr && bank_monitor == m_bank, "R1 hold", pc_out, m_pc);
            return;
        end
        chk(update_stb == 1, "R7 strobe", 32'(update_stb), 1);
        chk(link_out == m_link, "R7 link", link_out, m_link);
        chk(spsr_out == m_spsr, "R7 spsr", spsr_out, m_spsr);
        chk(bank_monitor == m_bank, mon ? "R2 bank" : "R4 bank", 32'(bank_monitor), 32'(m_bank));
        rp = mon ? "R2 pc" : (ve ? "R8 pc" : "R9 pc");
        chk(pc_out == m_pc, rp, pc_out, m_pc);
        chk(cpsr_out[4:0] == m_cpsr[4:0], mon ? "R2 mode" : "R4 mode", cpsr_out, m_cpsr);
        chk(cpsr_out[9:6] == m_cpsr[9:6], mon ? "R3 masks" : "R5 masks", cpsr_out, m_cpsr);
        chk(cpsr_out[5] == 0 && cpsr_out[24] == 0, "R6 state", cpsr_out, m_cpsr);
        chk((cpsr_out & 32'hFEFF_FC00) == (m_cpsr & 32'hFEFF_FC00), "R10 pass", cpsr_out, m_cpsr);
    endtask

    // apply inputs, clock once, update the model, compare after the edge
    task automatic step();
        bit took, mon, ve;
        took = rst_n && irq_req && !cpsr_in[7];
        mon = trap_to_monitor;
        ve = vectored_en;
        @(posedge clk);
        model_step();
        #1;
        compare(took, mon, ve);
    endtask

    task automatic rand_inputs();
        cpsr_in         = $urandom;
        monitor_base    = $urandom & 32'hFFFF_FFE0;
        nonsecure_base  = $urandom & 32'hFFFF_FFE0;
        handler_addr    = $urandom;
        next_instr_addr = $urandom & 32'hFFFF_FFFC;
        ee_secure       = 1'($urandom);
        ee_nonsecure    = 1'($urandom);
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; irq_req = 0; cpsr_in = 0; trap_to_monitor = 0; abort_mask_on_irq = 0;
        ee_secure = 0; ee_nonsecure = 0; vectored_en = 0; high_vectors = 0;
        monitor_base = 0; nonsecure_base = 0; handler_addr = 0; next_instr_addr = 0;
        m_cpsr = 0; m_spsr = 0; m_link = 0; m_pc = 0; m_bank = 0; m_stb = 0;
        #1;
        // R11: reset with a pending request must still clear everything
        irq_req = 1;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1;
        // All sixteen control combinations, accepted (R2..R10)
        for (int rep = 0; rep < 3; rep++) begin
            for (int c = 0; c < 16; c++) begin
                rand_inputs();
                cpsr_in[7]        = 0;
                trap_to_monitor   = c[0];
                abort_mask_on_irq = c[1];
                vectored_en       = c[2];
                high_vectors      = c[3];
                cpsr_in[6]        = rep[0];
                cpsr_in[8]        = rep[1] ^ c[0];
                irq_req = 1;
                step();
                // R1: masked request and idle cycle after a distinctive entry
                rand_inputs();
                cpsr_in[7] = 1;
                trap_to_monitor = ~trap_to_monitor;
                step();
                rand_inputs();
                irq_req = 0;
                cpsr_in[7] = 0;
                step();
            end
        end
        // random traffic
        for (int k = 0; k < 400; k++) begin
            rand_inputs();
            irq_req           = 1'($urandom);
            trap_to_monitor   = 1'($urandom);
            abort_mask_on_irq = 1'($urandom);
            vectored_en       = 1'($urandom);
            high_vectors      = 1'($urandom);
            step();
        end
        // R11: reset after activity
        rst_n = 0;
        step();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule